// File: doc/BRIEF.md
# Receive Buffer Descriptor Engine

The engine writes incoming Ethernet frames into memory buffers. The buffers are described by a small ring of receive descriptors held in memory. Each descriptor takes four 32-bit words at consecutive byte offsets. Offset 0 holds the buffer address. Offset 4 holds the length: software loads the buffer capacity there, and the engine writes back the count of stored bytes. Offset 8 is unused. Offset 12 is the control/status word. Frame bytes come in on a byte stream with a ready/valid handshake. Memory is reached through a single word-wide port. Reads on that port return data one cycle after the request. Writes complete in the cycle they are issued.

When a frame starts, the engine reads the current descriptor and decides whether it may use it. If it may, the engine packs the bytes little-endian into words and writes them to the buffer, truncating at the buffer capacity. It then writes back the length and the control word, with the full flag set and a status field. Finally it raises a sticky per-entry done flag and moves to the next ring entry. A frame that finds no usable descriptor is consumed and discarded, and a no-buffer counter counts it. Software hands a buffer back in two steps: it clears the full flag in memory, then pulses the matching bit on the free-buffer input.

Top module: `rx_desc_engine`

## Requirements
- R1: After reset, `done_o`, `nobuf_cnt_o`, `init_done_o`, `rx_ready_o` and `mem_req_o` are all 0.
- R2: An `init_i` pulse taken while the engine is idle does four things: it latches `ring_base_i`, selects entry 0, marks every entry not free, and drives `init_done_o` high from the next cycle on. No frame is started before `init_done_o` is high.
- R3: When a frame starts, the engine issues three reads on consecutive cycles at `base + 16*index` plus 0, 4 and 12. `rx_ready_o` stays low while these reads are in flight.
- R4: An entry is used only if all three hold: control bit 29 (enable) is 1, control bit 28 (full) is 0, and the entry has been freed. Otherwise every byte of the frame is accepted and no memory write occurs. `nobuf_cnt_o` increments by one, and the ring index is unchanged.
- R5: Stored byte k goes to byte address `(ptr & ~3) + k`, which is lane k mod 4 of its word, in bits 8*lane+7:8*lane. A word is written when lane 3 fills, or when the byte is the last one to be stored. The byte enables cover lanes 0 up to the current lane.
- R6: Bytes beyond the capacity (length word bits 10:0) are discarded. Status bit 0 (overflow) is then written as 1.
- R7: After the last byte, the engine writes the stored byte count to offset 4, then writes the control word to offset 12. The new control word keeps bits 31:29 and 27:16, sets bit 28, and carries the status in bits 15:0: bit 0 is overflow and the other status bits are 0.
- R8: `done_o[index]` goes high the cycle after the control write and stays high. A 1 on `ack_i` clears a done bit. If a set and a clear hit the same bit in the same cycle, the set wins.
- R9: After a stored frame, the index becomes 0 if control bit 31 (wrap) is set or the entry is the last one in the ring. Otherwise it becomes index+1.
- R10: Filling an entry withdraws its free mark. The entry is refused (R4) until a `free_wr_i` pulse with its bit set in `free_i`, even after full has been cleared in memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| init_i | input | 1 | Init command pulse |
| ring_base_i | input | AW | Byte address of descriptor entry 0 |
| init_done_o | output | 1 | Init completed |
| rx_valid_i | input | 1 | Frame byte valid |
| rx_data_i | input | 8 | Frame byte |
| rx_last_i | input | 1 | Byte is the last of the frame |
| rx_ready_o | output | 1 | Byte accepted when high together with valid |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Access is a write |
| mem_addr_o | output | AW | Byte address, word aligned |
| mem_wdata_o | output | 32 | Write data |
| mem_be_o | output | 4 | Write byte enables |
| mem_rdata_i | input | 32 | Read data, one cycle after the request |
| free_wr_i | input | 1 | Free-buffer register write strobe |
| free_i | input | NUM_DESC | Entries handed back to the engine |
| ack_i | input | NUM_DESC | Done bits to clear (write 1 to clear) |
| done_o | output | NUM_DESC | Sticky per-entry frame-done flags |
| nobuf_cnt_o | output | CNT_W | Count of frames dropped for lack of a buffer |

## Verification
Two functions can fall in the same cycle: the engine setting a done bit as it writes the control word, and software clearing done bits through `ack_i`. The bench drives `ack_i` in the exact cycle of the control write, covering both the bit being set and a different bit that is already set. It then expects the new bit to remain high and the other to drop. Every memory access is compared, cycle by cycle, against a queue of accesses that the bench model predicts from the descriptor contents and the frame. This catches wrong ordering, wrong lanes and spurious writes on dropped frames.

// File: rtl/rxbd_pkg.sv
package rxbd_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_RD_PTR, ST_RD_LEN, ST_RD_CTL, ST_CHK,
    ST_RECV, ST_DROP, ST_WB_LEN, ST_WB_CTL
  } rxbd_state_e;

  localparam int unsigned CTL_FULL = 28;
  localparam int unsigned CTL_EN   = 29;
  localparam int unsigned CTL_WRAP = 31;
  localparam int unsigned STS_OVF  = 0;

  localparam logic [3:0] OFS_PTR = 4'd0;
  localparam logic [3:0] OFS_LEN = 4'd4;
  localparam logic [3:0] OFS_CTL = 4'd12;
endpackage

// File: rtl/rxbd_packer.sv
module rxbd_packer (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        push_i,
  input  logic [1:0]  lane_i,
  input  logic [7:0]  byte_i,
  output logic [31:0] word_o,
  output logic [3:0]  be_o
);
  logic [23:0] held_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      held_q <= '0;
    end else if (push_i) begin
      case (lane_i)
        2'd0:    held_q[7:0]   <= byte_i;
        2'd1:    held_q[15:8]  <= byte_i;
        2'd2:    held_q[23:16] <= byte_i;
        default: ;
      endcase
    end
  end

  always_comb begin
    word_o = {8'h00, held_q};
    case (lane_i)
      2'd0:    begin word_o[7:0]   = byte_i; be_o = 4'b0001; end
      2'd1:    begin word_o[15:8]  = byte_i; be_o = 4'b0011; end
      2'd2:    begin word_o[23:16] = byte_i; be_o = 4'b0111; end
      default: begin word_o[31:24] = byte_i; be_o = 4'b1111; end
    endcase
  end

  AST_BE_HAS_LANE0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> be_o[0]); // R5
endmodule

// File: rtl/rxbd_flags.sv
module rxbd_flags #(
  parameter int unsigned NUM_DESC = 4,
  parameter int unsigned IDX_W    = 2,
  parameter int unsigned CNT_W    = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                init_i,
  input  logic                free_wr_i,
  input  logic [NUM_DESC-1:0] free_i,
  input  logic [NUM_DESC-1:0] ack_i,
  input  logic                fill_i,
  input  logic [IDX_W-1:0]    fill_idx_i,
  input  logic                drop_i,
  output logic [NUM_DESC-1:0] done_o,
  output logic [NUM_DESC-1:0] avail_o,
  output logic [CNT_W-1:0]    nobuf_o
);
  logic [NUM_DESC-1:0] done_q, avail_q;
  logic [CNT_W-1:0]    nobuf_q;

  for (genvar g = 0; g < NUM_DESC; g++) begin : g_ent
    logic hit, d_q, a_q;
    assign hit = fill_i && (fill_idx_i == IDX_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        d_q <= 1'b0;
        a_q <= 1'b0;
      end else begin
        d_q <= hit | (d_q & ~ack_i[g]);   // set beats clear
        if (free_wr_i && free_i[g])  a_q <= 1'b1;
        else if (init_i || hit)      a_q <= 1'b0;
      end
    end

    assign done_q[g]  = d_q;
    assign avail_q[g] = a_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     nobuf_q <= '0;
    else if (drop_i) nobuf_q <= nobuf_q + CNT_W'(1);
  end

  assign done_o  = done_q;
  assign avail_o = avail_q;
  assign nobuf_o = nobuf_q;

  AST_DONE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_q & ~ack_i) != '0 |=> ((done_q & $past(done_q & ~ack_i)) == $past(done_q & ~ack_i))); // R8
  AST_DONE_ON_FILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_i |=> done_q[$past(fill_idx_i)]); // R8
  AST_NOBUF_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drop_i |=> nobuf_q == $past(nobuf_q) + CNT_W'(1)); // R4
  AST_FILL_WITHDRAWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_i && !free_wr_i) |=> !avail_q[$past(fill_idx_i)]); // R10
endmodule

// File: rtl/rx_desc_engine.sv
module rx_desc_engine
  import rxbd_pkg::*;
#(
  parameter int unsigned NUM_DESC = 4,
  parameter int unsigned AW       = 32,
  parameter int unsigned LEN_W    = 11,
  parameter int unsigned CNT_W    = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                init_i,
  input  logic [AW-1:0]       ring_base_i,
  output logic                init_done_o,
  input  logic                rx_valid_i,
  input  logic [7:0]          rx_data_i,
  input  logic                rx_last_i,
  output logic                rx_ready_o,
  output logic                mem_req_o,
  output logic                mem_we_o,
  output logic [AW-1:0]       mem_addr_o,
  output logic [31:0]         mem_wdata_o,
  output logic [3:0]          mem_be_o,
  input  logic [31:0]         mem_rdata_i,
  input  logic                free_wr_i,
  input  logic [NUM_DESC-1:0] free_i,
  input  logic [NUM_DESC-1:0] ack_i,
  output logic [NUM_DESC-1:0] done_o,
  output logic [CNT_W-1:0]    nobuf_cnt_o
);
  localparam int unsigned IDX_W = (NUM_DESC > 1) ? $clog2(NUM_DESC) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_DESC - 1);

  rxbd_state_e         state_q;
  logic [IDX_W-1:0]    idx_q;
  logic [AW-1:0]       base_q, ptr_q;
  logic [LEN_W-1:0]    cap_q, cnt_q;
  logic [31:0]         ctl_q;
  logic                ovf_q, init_done_q;
  logic [NUM_DESC-1:0] avail;

  logic          accept, store, flush, usable, init_go, fill, drop;
  logic [AW-1:0] desc_addr;
  logic [31:0]   pk_word;
  logic [3:0]    pk_be;
  logic [15:0]   status;

  assign init_go   = (state_q == ST_IDLE) && init_i;
  assign rx_ready_o = (state_q == ST_RECV) || (state_q == ST_DROP);
  assign accept    = rx_valid_i && rx_ready_o;
  assign store     = (state_q == ST_RECV) && accept && (cnt_q < cap_q);
  assign flush     = store && ((cnt_q[1:0] == 2'd3) || rx_last_i || (cnt_q == cap_q - LEN_W'(1)));
  assign desc_addr = base_q + (AW'(idx_q) << 4);
  assign usable    = avail[idx_q] && mem_rdata_i[CTL_EN] && !mem_rdata_i[CTL_FULL];
  assign fill      = (state_q == ST_WB_CTL);
  assign drop      = (state_q == ST_DROP) && accept && rx_last_i;
  assign status    = 16'(ovf_q) << STS_OVF;

  rxbd_packer i_packer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .push_i (store),
    .lane_i (cnt_q[1:0]),
    .byte_i (rx_data_i),
    .word_o (pk_word),
    .be_o   (pk_be)
  );

  rxbd_flags #(
    .NUM_DESC (NUM_DESC),
    .IDX_W    (IDX_W),
    .CNT_W    (CNT_W)
  ) i_flags (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .init_i     (init_go),
    .free_wr_i  (free_wr_i),
    .free_i     (free_i),
    .ack_i      (ack_i),
    .fill_i     (fill),
    .fill_idx_i (idx_q),
    .drop_i     (drop),
    .done_o     (done_o),
    .avail_o    (avail),
    .nobuf_o    (nobuf_cnt_o)
  );

  always_comb begin
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = '0;
    mem_wdata_o = '0;
    mem_be_o    = '0;
    case (state_q)
      ST_RD_PTR: begin mem_req_o = 1'b1; mem_addr_o = desc_addr + AW'(OFS_PTR); end
      ST_RD_LEN: begin mem_req_o = 1'b1; mem_addr_o = desc_addr + AW'(OFS_LEN); end
      ST_RD_CTL: begin mem_req_o = 1'b1; mem_addr_o = desc_addr + AW'(OFS_CTL); end
      ST_RECV: if (flush) begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = ptr_q + AW'({cnt_q[LEN_W-1:2], 2'b00});
        mem_wdata_o = pk_word;
        mem_be_o    = pk_be;
      end
      ST_WB_LEN: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = desc_addr + AW'(OFS_LEN);
        mem_wdata_o = 32'(cnt_q);
        mem_be_o    = 4'hf;
      end
      ST_WB_CTL: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = desc_addr + AW'(OFS_CTL);
        mem_wdata_o = {ctl_q[31:29], 1'b1, ctl_q[27:16], status};
        mem_be_o    = 4'hf;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      idx_q       <= '0;
      base_q      <= '0;
      ptr_q       <= '0;
      cap_q       <= '0;
      cnt_q       <= '0;
      ctl_q       <= '0;
      ovf_q       <= 1'b0;
      init_done_q <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (init_i) begin
            base_q      <= ring_base_i & ~AW'(3);
            idx_q       <= '0;
            init_done_q <= 1'b1;
          end else if (rx_valid_i && init_done_q) begin
            state_q <= ST_RD_PTR;
          end
        end
        ST_RD_PTR: state_q <= ST_RD_LEN;
        ST_RD_LEN: begin
          ptr_q   <= AW'(mem_rdata_i) & ~AW'(3);
          state_q <= ST_RD_CTL;
        end
        ST_RD_CTL: begin
          cap_q   <= mem_rdata_i[LEN_W-1:0];
          state_q <= ST_CHK;
        end
        ST_CHK: begin
          ctl_q   <= mem_rdata_i;
          cnt_q   <= '0;
          ovf_q   <= 1'b0;
          state_q <= usable ? ST_RECV : ST_DROP;
        end
        ST_RECV: if (accept) begin
          if (store) cnt_q <= cnt_q + LEN_W'(1);
          else       ovf_q <= 1'b1;
          if (rx_last_i) state_q <= ST_WB_LEN;
        end
        ST_DROP: if (accept && rx_last_i) state_q <= ST_IDLE;
        ST_WB_LEN: state_q <= ST_WB_CTL;
        ST_WB_CTL: begin
          idx_q   <= (ctl_q[CTL_WRAP] || idx_q == LAST_IDX) ? '0 : idx_q + IDX_W'(1);
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign init_done_o = init_done_q;

  AST_INIT_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_go |=> init_done_o); // R2
  AST_BUF_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RECV && mem_we_o) |-> (mem_addr_o - ptr_q) < AW'(cap_q)); // R5
  AST_LEN_CAPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WB_LEN) |-> mem_wdata_o[LEN_W-1:0] <= cap_q); // R6
  AST_DROP_KEEPS_INDEX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DROP) |=> idx_q == $past(idx_q)); // R4
  AST_WRAP_TO_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WB_CTL && ctl_q[CTL_WRAP]) |=> idx_q == '0); // R9
  AST_FETCH_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RD_PTR || state_q == ST_RD_LEN || state_q == ST_RD_CTL) |-> !accept); // R3
endmodule

// File: tb/test_rx_desc_engine.sv
`timescale 1ns/1ps
module test_rx_desc_engine;
  localparam int N = 4;
  localparam logic [31:0] BASE = 32'h100;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        init_i = 1'b0;
  logic [31:0] ring_base_i = '0;
  logic        init_done_o;
  logic        rx_valid_i = 1'b0;
  logic [7:0]  rx_data_i = '0;
  logic        rx_last_i = 1'b0;
  logic        rx_ready_o;
  logic        mem_req_o, mem_we_o;
  logic [31:0] mem_addr_o, mem_wdata_o;
  logic [3:0]  mem_be_o;
  logic [31:0] mem_rdata_i = '0;
  logic        free_wr_i = 1'b0;
  logic [N-1:0] free_i = '0;
  logic [N-1:0] ack_i = '0;
  logic [N-1:0] done_o;
  logic [15:0] nobuf_cnt_o;

  always #4 clk_i = ~clk_i;  // 125 MHz

  rx_desc_engine i_rx_desc_engine (
    .clk_i(clk_i), .rst_ni(rst_ni), .init_i(init_i), .ring_base_i(ring_base_i),
    .init_done_o(init_done_o), .rx_valid_i(rx_valid_i), .rx_data_i(rx_data_i),
    .rx_last_i(rx_last_i), .rx_ready_o(rx_ready_o), .mem_req_o(mem_req_o),
    .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
    .mem_be_o(mem_be_o), .mem_rdata_i(mem_rdata_i), .free_wr_i(free_wr_i),
    .free_i(free_i), .ack_i(ack_i), .done_o(done_o), .nobuf_cnt_o(nobuf_cnt_o)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // memory model
  logic [31:0] mem [int unsigned];

  function automatic logic [31:0] rd(input logic [31:0] a);
    if (mem.exists(a >> 2)) return mem[a >> 2];
    return 32'h0;
  endfunction

  task automatic poke(input logic [31:0] a, input logic [31:0] d);
    mem[a >> 2] = d;
  endtask

  always @(posedge clk_i) begin : mem_model
    logic [31:0] w;
    if (mem_req_o && !mem_we_o) mem_rdata_i <= rd(mem_addr_o);
    if (mem_req_o && mem_we_o) begin
      w = rd(mem_addr_o);
      for (int j = 0; j < 4; j++) if (mem_be_o[j]) w[8*j +: 8] = mem_wdata_o[8*j +: 8];
      mem[mem_addr_o >> 2] = w;
    end
  end

  // expected access queues
  logic [31:0] ex_addr[$];
  logic [31:0] ex_data[$];
  logic [3:0]  ex_be[$];
  bit          ex_we[$];
  string       ex_tag[$];

  task automatic expect_acc(input bit we, input logic [31:0] a, input logic [31:0] d,
                            input logic [3:0] be, input string tag);
    ex_we.push_back(we); ex_addr.push_back(a); ex_data.push_back(d);
    ex_be.push_back(be); ex_tag.push_back(tag);
  endtask

  // per-clock comparison of the memory port
  always @(negedge clk_i) begin : port_monitor
    logic [31:0] m;
    if (rst_ni && !finished && mem_req_o) begin
      if (ex_addr.size() == 0) begin
        chk(1'b0, mem_we_o ? "R4 unexpected write" : "R3 unexpected read", mem_addr_o, 32'h0);
      end else begin
        m = {{8{ex_be[0][3]}}, {8{ex_be[0][2]}}, {8{ex_be[0][1]}}, {8{ex_be[0][0]}}};
        chk(mem_we_o == ex_we[0], {ex_tag[0], " direction"}, 32'(mem_we_o), 32'(ex_we[0]));
        chk(mem_addr_o == ex_addr[0], {ex_tag[0], " address"}, mem_addr_o, ex_addr[0]);
        if (ex_we[0]) begin
          chk(mem_be_o == ex_be[0], {ex_tag[0], " byte enables"}, 32'(mem_be_o), 32'(ex_be[0]));
          chk((mem_wdata_o & m) == (ex_data[0] & m), {ex_tag[0], " data"}, mem_wdata_o & m, ex_data[0] & m);
        end
        void'(ex_we.pop_front()); void'(ex_addr.pop_front()); void'(ex_data.pop_front());
        void'(ex_be.pop_front()); void'(ex_tag.pop_front());
      end
    end
  end

  // behavioural reference state
  int       m_idx = 0;
  bit [N-1:0] m_avail = '0;
  bit [N-1:0] m_done = '0;
  int       m_nobuf = 0;

  task automatic plan_frame(input int n, input int seed);
    logic [31:0] a, ptr, ctl, w;
    logic [3:0]  be;
    int cap, stored;
    a = BASE + 32'(16 * m_idx);
    expect_acc(1'b0, a,      '0, '0, "R3 fetch pointer");
    expect_acc(1'b0, a + 4,  '0, '0, "R3 fetch length");
    expect_acc(1'b0, a + 12, '0, '0, "R3 fetch control");
    ptr = rd(a) & ~32'h3;
    cap = int'(rd(a + 4) & 32'h7ff);
    ctl = rd(a + 12);
    if (m_avail[m_idx] && ctl[29] && !ctl[28]) begin
      stored = (n < cap) ? n : cap;
      for (int k = 0; k < stored; k += 4) begin
        w = '0; be = '0;
        for (int j = 0; j < 4; j++)
          if (k + j < stored) begin
            w[8*j +: 8] = 8'(seed + k + j);
            be[j] = 1'b1;
          end
        expect_acc(1'b1, ptr + 32'(k), w, be, "R5 buffer word");
      end
      expect_acc(1'b1, a + 4, 32'(stored), 4'hf, "R7 length writeback");
      expect_acc(1'b1, a + 12, {ctl[31:29], 1'b1, ctl[27:16], 15'h0, (n > cap) ? 1'b1 : 1'b0}, 4'hf,
                 (n > cap) ? "R6 control with overflow" : "R7 control writeback");
      m_avail[m_idx] = 1'b0;
      m_done[m_idx]  = 1'b1;
      m_idx = (ctl[31] || m_idx == N - 1) ? 0 : m_idx + 1;
    end else begin
      m_nobuf++;
    end
  endtask

  task automatic send_frame(input int n, input int seed);
    bit got;
    for (int k = 0; k < n; k++) begin
      rx_valid_i = 1'b1;
      rx_data_i  = 8'(seed + k);
      rx_last_i  = (k == n - 1);
      do begin
        @(negedge clk_i); got = rx_ready_o;
        @(posedge clk_i); #2;
      end while (!got);
    end
    rx_valid_i = 1'b0;
    rx_last_i  = 1'b0;
  endtask

  task automatic wait_quiet();
    while (ex_addr.size() != 0) @(posedge clk_i);
    repeat (3) @(posedge clk_i);
    #2;
  endtask

  task automatic check_flags(input string tag);
    chk(done_o == m_done, {tag, " R8 done flags"}, 32'(done_o), 32'(m_done));
    chk(nobuf_cnt_o == 16'(m_nobuf), {tag, " R4 no-buffer count"}, 32'(nobuf_cnt_o), 32'(m_nobuf));
  endtask

  task automatic free_pulse(input logic [N-1:0] bits);
    free_wr_i = 1'b1; free_i = bits;
    @(posedge clk_i); #2;
    free_wr_i = 1'b0; free_i = '0;
    for (int g = 0; g < N; g++) if (bits[g]) m_avail[g] = 1'b1;
  endtask

  // watchdog
  int cyc = 0;
  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 50000 && !finished) begin
      finished = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog R3 actual=%0d expected=%0d", cyc, 50000);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      poke(BASE + 32'(16*i),      32'h1000 + 32'(32'h100 * i));
      poke(BASE + 32'(16*i) + 4,  32'd1522);
      poke(BASE + 32'(16*i) + 8,  32'h0);
      poke(BASE + 32'(16*i) + 12, 32'h2000_0000);
      for (int k = 0; k < 64; k++) poke(32'h1000 + 32'(32'h100 * i) + 32'(4*k), 32'h0);
    end
    poke(BASE + 16 + 4, 32'd5);        // entry 1: capacity 5
    poke(BASE + 32 + 12, 32'h0);       // entry 2: disabled

    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    // R1 reset state
    chk(done_o == '0, "R1 done after reset", 32'(done_o), 0);
    chk(nobuf_cnt_o == '0, "R1 count after reset", 32'(nobuf_cnt_o), 0);
    chk(init_done_o == 1'b0, "R1 init_done after reset", 32'(init_done_o), 0);
    chk(rx_ready_o == 1'b0, "R1 ready after reset", 32'(rx_ready_o), 0);
    chk(mem_req_o == 1'b0, "R1 no access after reset", 32'(mem_req_o), 0);
    @(posedge clk_i); #2;
    rst_ni = 1'b1;
    @(posedge clk_i); #2;

    // R2 init
    ring_base_i = BASE; init_i = 1'b1;
    @(posedge clk_i); #2;
    init_i = 1'b0;
    chk(init_done_o == 1'b1, "R2 init_done", 32'(init_done_o), 1);

    // entry 0 enabled but never freed: dropped
    plan_frame(9, 8'h10); send_frame(9, 8'h10); wait_quiet(); check_flags("F1");

    free_pulse(4'b1111);
    plan_frame(9, 8'h20); send_frame(9, 8'h20); wait_quiet(); check_flags("F2");
    // entry 1 capacity 5, frame 7: overflow
    plan_frame(7, 8'h30); send_frame(7, 8'h30); wait_quiet(); check_flags("F3");
    // entry 2 disabled: dropped, index held
    plan_frame(5, 8'h40); send_frame(5, 8'h40); wait_quiet(); check_flags("F4");
    poke(BASE + 32 + 12, 32'h2000_0000);
    plan_frame(8, 8'h50); send_frame(8, 8'h50); wait_quiet(); check_flags("F5");
    // entry 3: last in ring, index returns to 0 (R9)
    plan_frame(3, 8'h60); send_frame(3, 8'h60); wait_quiet(); check_flags("F6 R9");

    // R10: full cleared but no free pulse -> still refused
    poke(BASE + 12, 32'hA000_0000);
    plan_frame(4, 8'h70); send_frame(4, 8'h70); wait_quiet(); check_flags("F7 R10");

    free_pulse(4'b0001);
    // ack in the very cycle of the control write: bit0 set wins, bit1 clears
    plan_frame(12, 8'h80); send_frame(12, 8'h80);
    @(posedge clk_i); #2;
    ack_i = 4'b0011;
    @(posedge clk_i); #2;
    ack_i = '0;
    m_done[1] = 1'b0;
    wait_quiet(); check_flags("F8 same-cycle ack");

    // plain write-1-to-clear
    ack_i = 4'b1100;
    @(posedge clk_i); #2;
    ack_i = '0;
    m_done[3:2] = 2'b00;
    @(posedge clk_i); #2;
    check_flags("ack clear");

    // wrap bit on entry 0 kept index at 0; entry 0 not freed again -> drop
    plan_frame(6, 8'h90); send_frame(6, 8'h90); wait_quiet(); check_flags("F9 R9 R10");

    chk(ex_addr.size() == 0, "R3 pending accesses", 32'(ex_addr.size()), 0);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule